// File: doc/BRIEF.md
# CAN Bit-Level Error Detector

This block watches a CAN node one sampled bit at a time and raises a one-cycle pulse for each protocol rule the bit breaks. A separate frame sequencer tells it where the current bit lies in the frame: start of frame, arbitration, data, CRC sequence, CRC delimiter, ACK slot, ACK delimiter, end of frame or interframe space. It also tells the block whether the bit is a stuff bit and whether this node is the transmitter. The block needs the driven bit and the sampled bus level for each strobe. It checks the bus level against the driven bit, keeps its own count of equal bits in a row, flags dominant levels where the format requires recessive, checks the acknowledge slot, and carries its own CRC of the frame, which it compares with the received CRC sequence.

Each error has its own output. A 3-bit code gives the most important error of the cycle, so an error-frame generator can act on it. The bus levels are dominant = 0 and recessive = 1. Only bits that arrive with the sample strobe high are evaluated. All outputs are registered, so they appear in the clock cycle after the strobe.

Top module: `can_err_detect`

## Requirements
- R1: With `is_tx` high, a sampled bit whose bus level differs from `tx_bit` raises `err_bit`, whether a dominant (0) bit was driven and a recessive (1) level was read, or the reverse. With `is_tx` low, no bit error is raised.
- R2: When a recessive bit is driven and a dominant level is read in the arbitration field or the ACK slot, no bit error is raised.
- R3: The block counts consecutive sampled bits of equal level, and stuff bits count toward this run. The run restarts at 1 when the level changes and at start of frame. When a sixth equal bit arrives in the start of frame, arbitration, data, CRC sequence or CRC delimiter field, `err_stuff` is raised. A run of exactly five raises nothing.
- R4: No stuff error is raised in the ACK slot, ACK delimiter, end of frame or interframe space, however long the run.
- R5: A dominant (0) level sampled in the CRC delimiter, ACK delimiter, end of frame or interframe space raises `err_form`.
- R6: With `is_tx` high, a recessive (1) level sampled in the ACK slot raises `err_ack`. A dominant level there, or `is_tx` low, raises nothing.
- R7: The CRC uses the 15-bit generator 0x4599 and starts from zero at start of frame. It is computed over the non-stuff bits of start of frame, arbitration and data. The non-stuff bits of the CRC sequence are gathered MSB first. At the CRC delimiter strobe, a difference between the two raises `err_crc`.
- R8: Error outputs are high only in the one cycle that follows a strobe with `smp_stb` high. Inputs without a strobe cause no error.
- R9: `err_code` is 0 with no error. Otherwise it is the highest-priority error that is present: 1 bit, 2 stuff, 3 form, 4 ack, 5 CRC. `err_any` is high when any error output is high.
- R10: While `rst_n` is low, all error outputs and `err_code` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe: a bit has been sampled |
| tx_bit | input | 1 | Level this node drove for the bit |
| rx_bit | input | 1 | Sampled bus level (0 dominant) |
| is_tx | input | 1 | This node is transmitting the frame |
| stuff_bit | input | 1 | The sampled bit is a stuff bit |
| fld_sof | input | 1 | Bit is start of frame |
| fld_arb | input | 1 | Bit is in the arbitration field |
| fld_data | input | 1 | Bit is in the control or data field |
| fld_crc | input | 1 | Bit is in the CRC sequence |
| fld_crc_dlm | input | 1 | Bit is the CRC delimiter |
| fld_ack_slot | input | 1 | Bit is the ACK slot |
| fld_ack_dlm | input | 1 | Bit is the ACK delimiter |
| fld_eof | input | 1 | Bit is in end of frame |
| fld_ifs | input | 1 | Bit is in interframe space |
| err_bit | output | 1 | Bit error pulse |
| err_stuff | output | 1 | Stuff error pulse |
| err_form | output | 1 | Form error pulse |
| err_ack | output | 1 | Acknowledge error pulse |
| err_crc | output | 1 | CRC mismatch pulse |
| err_any | output | 1 | Any error pulse |
| err_code | output | 3 | Highest-priority error code |

## Verification
The assertions assume that at most one field indicator is high at each strobe, and one of them checks this. They also assume the sequencer marks stuff bits correctly, because the CRC result depends on it. The stimulus sets exactly one field per strobe, or none between strobes. The whole frames in the bench are stuffed by a bench-side stuffer, which marks every inserted bit. Strobes are separated by a low cycle, so each error pulse can be traced back to the strobe before it.

// File: rtl/can_err_pkg.sv
// Package: types shared by the CAN bit-level error detector.
// Assumes bus level 0 is dominant and 1 is recessive.
package can_err_pkg;

    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;

    // Error codes; a lower non-zero value has higher priority.
    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_BIT   = 3'd1,
        ERR_STUFF = 3'd2,
        ERR_FORM  = 3'd3,
        ERR_ACK   = 3'd4,
        ERR_CRC   = 3'd5
    } err_code_e;

    // One flag per error check.
    typedef struct packed {
        logic crc;
        logic ack;
        logic form;
        logic stuff;
        logic bits;
    } err_vec_t;

    // Priority encode an error vector into its code.
    function automatic err_code_e encode_err(input err_vec_t v);
        err_code_e c;
        if (v.bits)       c = ERR_BIT;
        else if (v.stuff) c = ERR_STUFF;
        else if (v.form)  c = ERR_FORM;
        else if (v.ack)   c = ERR_ACK;
        else if (v.crc)   c = ERR_CRC;
        else              c = ERR_NONE;
        return c;
    endfunction

endpackage

// File: rtl/can_crc_unit.sv
// CRC unit: computes the frame CRC over the non-stuff bits of start of frame,
// arbitration and data. It gathers the non-stuff bits of the received CRC
// sequence MSB first, and reports a mismatch at the CRC delimiter strobe.
// Assumes: exactly one field flag is high per strobe, and stuff bits are marked.
module can_crc_unit #(
    parameter int          CRC_W    = 15,
    parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic rx,
    input  logic stuff,
    input  logic f_sof,
    input  logic f_cover,
    input  logic f_crcfld,
    input  logic f_check,
    output logic crc_err
);

    logic [CRC_W-1:0] calc_q;
    logic [CRC_W-1:0] recv_q;
    logic [CRC_W-1:0] calc_base;
    logic [CRC_W-1:0] calc_shift;
    logic [CRC_W-1:0] calc_d;
    logic             feedback;

    // Next CRC value; start of frame restarts from zero.
    always_comb begin
        calc_base  = f_sof ? '0 : calc_q;
        feedback   = rx ^ calc_base[CRC_W-1];
        calc_shift = {calc_base[CRC_W-2:0], 1'b0};
        calc_d     = feedback ? (calc_shift ^ CRC_POLY) : calc_shift;
    end

    // Update the running CRC and the received CRC shift register on non-stuff bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calc_q <= '0;
            recv_q <= '0;
        end else if (stb && !stuff) begin
            if (f_sof || f_cover) calc_q <= calc_d;
            if (f_crcfld)         recv_q <= {recv_q[CRC_W-2:0], rx};
        end
    end

    // Compare at the delimiter.
    always_comb crc_err = stb && f_check && (calc_q != recv_q);

    // R7: stuff bits leave both CRC registers untouched.
    p_stuff_excluded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && stuff) |=> ($stable(calc_q) && $stable(recv_q)))
        else $error("stuff bit changed CRC state");

    // R7: the running CRC does not move while the CRC sequence arrives.
    p_crc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && f_crcfld) |=> $stable(calc_q))
        else $error("CRC changed inside CRC field");

endmodule

// File: rtl/can_run_checker.sv
// Run checker: counts consecutive sampled bits of equal level, stuff bits
// included. It flags the sixth equal bit inside the stuffing window
// (start of frame through the CRC delimiter).
// Assumes: exactly one field flag is high per strobe.
module can_run_checker #(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic rx,
    input  logic f_sof,
    input  logic in_window,
    output logic stuff_err
);

    localparam int               RUN_W   = $clog2(RUN_LIMIT + 2);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(RUN_LIMIT);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT + 1);

    logic [RUN_W-1:0] cnt_q;
    logic [RUN_W-1:0] cnt_d;
    logic             last_q;
    logic             same;

    // Next run length: restart on change or SOF, saturate at the maximum.
    always_comb begin
        same = (rx == last_q);
        if (f_sof || !same)      cnt_d = RUN_ONE;
        else if (cnt_q < RUN_MAX) cnt_d = cnt_q + RUN_ONE;
        else                     cnt_d = cnt_q;
    end

    // Run-length state, advanced on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= RUN_ONE;
            last_q <= 1'b1;
        end else if (stb) begin
            cnt_q  <= cnt_d;
            last_q <= rx;
        end
    end

    // A new equal bit after RUN_LIMIT equal bits breaks the stuffing rule.
    always_comb stuff_err = stb && in_window && !f_sof && same && (cnt_q >= RUN_LIM);

    // R3: a level change restarts the run at one.
    p_run_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && (rx != last_q)) |=> (cnt_q == RUN_ONE))
        else $error("run did not restart");

    // R3: the run never grows past its saturation value.
    p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RUN_MAX)
        else $error("run counter overflow");

endmodule

// File: rtl/can_rule_checker.sv
// Rule checker: combinational bit, acknowledge and form checks for one
// sampled bit. Assumes the inputs are valid only while the strobe is high;
// the caller applies the strobe.
module can_rule_checker
    import can_err_pkg::*;
(
    input  logic tx,
    input  logic rx,
    input  logic is_tx,
    input  logic f_arb,
    input  logic f_ack_slot,
    input  logic f_fixed_rec,
    output logic bit_err,
    output logic ack_err,
    output logic form_err
);

    logic lost_arb_or_acked;

    // Bit monitor with the arbitration and ACK-slot exemption.
    always_comb begin
        lost_arb_or_acked = (f_arb || f_ack_slot) && (tx == LVL_REC) && (rx == LVL_DOM);
        bit_err = is_tx && (tx != rx) && !lost_arb_or_acked;
    end

    // Acknowledge check: the transmitter expects a dominant ACK slot.
    always_comb ack_err = is_tx && f_ack_slot && (rx == LVL_REC);

    // Form check: fixed-recessive fields must not read dominant.
    always_comb form_err = f_fixed_rec && (rx == LVL_DOM);

endmodule

// File: rtl/can_err_detect.sv
// CAN bit-level error detector top. It combines the rule, run and CRC
// checkers and registers the error pulses and a priority code. The outputs
// appear in the cycle after each sample strobe.
// Assumes: at most one field flag high per strobe; stuff bits marked.
module can_err_detect
    import can_err_pkg::*;
#(
    parameter int               RUN_LIMIT = 5,
    parameter int               CRC_W     = 15,
    parameter logic [CRC_W-1:0] CRC_POLY  = 15'h4599
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_stb,
    input  logic       tx_bit,
    input  logic       rx_bit,
    input  logic       is_tx,
    input  logic       stuff_bit,
    input  logic       fld_sof,
    input  logic       fld_arb,
    input  logic       fld_data,
    input  logic       fld_crc,
    input  logic       fld_crc_dlm,
    input  logic       fld_ack_slot,
    input  logic       fld_ack_dlm,
    input  logic       fld_eof,
    input  logic       fld_ifs,
    output logic       err_bit,
    output logic       err_stuff,
    output logic       err_form,
    output logic       err_ack,
    output logic       err_crc,
    output logic       err_any,
    output logic [2:0] err_code
);

    logic     stuff_window;
    logic     fixed_rec;
    logic     rule_bit;
    logic     rule_ack;
    logic     rule_form;
    logic     run_err;
    logic     crc_mis;
    err_vec_t err_d;
    err_vec_t err_q;
    err_code_e code_q;

    // Field groupings used by the checks.
    always_comb begin
        stuff_window = fld_sof || fld_arb || fld_data || fld_crc || fld_crc_dlm;
        fixed_rec    = fld_crc_dlm || fld_ack_dlm || fld_eof || fld_ifs;
    end

    can_rule_checker i_rule (
        .tx          (tx_bit),
        .rx          (rx_bit),
        .is_tx       (is_tx),
        .f_arb       (fld_arb),
        .f_ack_slot  (fld_ack_slot),
        .f_fixed_rec (fixed_rec),
        .bit_err     (rule_bit),
        .ack_err     (rule_ack),
        .form_err    (rule_form)
    );

    can_run_checker #(.RUN_LIMIT(RUN_LIMIT)) i_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (smp_stb),
        .rx        (rx_bit),
        .f_sof     (fld_sof),
        .in_window (stuff_window),
        .stuff_err (run_err)
    );

    can_crc_unit #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) i_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (smp_stb),
        .rx       (rx_bit),
        .stuff    (stuff_bit),
        .f_sof    (fld_sof),
        .f_cover  (fld_arb || fld_data),
        .f_crcfld (fld_crc),
        .f_check  (fld_crc_dlm),
        .crc_err  (crc_mis)
    );

    // Gather the strobe-qualified flags of this cycle.
    always_comb begin
        err_d.bits  = smp_stb && rule_bit;
        err_d.stuff = run_err;
        err_d.form  = smp_stb && rule_form;
        err_d.ack   = smp_stb && rule_ack;
        err_d.crc   = crc_mis;
    end

    // Register the pulses and their priority code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            code_q <= ERR_NONE;
        end else begin
            err_q  <= err_d;
            code_q <= encode_err(err_d);
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        err_bit   = err_q.bits;
        err_stuff = err_q.stuff;
        err_form  = err_q.form;
        err_ack   = err_q.ack;
        err_crc   = err_q.crc;
        err_any   = |err_q;
        err_code  = code_q;
    end

    // Input assumption: at most one field flag per strobe.
    p_fields_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> $onehot0({fld_sof, fld_arb, fld_data, fld_crc, fld_crc_dlm,
                              fld_ack_slot, fld_ack_dlm, fld_eof, fld_ifs}))
        else $error("more than one field flag");

    // R8: every error pulse follows a strobe.
    p_pulse_after_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> $past(smp_stb))
        else $error("error without strobe");

    // R2: no bit error for a lost arbitration bit or an acknowledged slot.
    p_bit_exempt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smp_stb && (fld_arb || fld_ack_slot) && tx_bit && !rx_bit) |-> !err_bit)
        else $error("bit error inside exemption");

    // R1: a bit error needs the transmitter role and a level mismatch.
    p_bit_needs_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_bit |-> $past(is_tx && (tx_bit != rx_bit)))
        else $error("bit error without mismatch");

    // R6: an acknowledge error needs the transmitter role and a recessive slot.
    p_ack_role_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_ack |-> $past(is_tx && fld_ack_slot && rx_bit))
        else $error("ack error out of place");

    // R5: a form error needs a dominant sample.
    p_form_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_form |-> $past(!rx_bit))
        else $error("form error on recessive");

    // R4: stuff errors only from inside the stuffing window.
    p_stuff_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_stuff |-> $past(fld_sof || fld_arb || fld_data || fld_crc || fld_crc_dlm))
        else $error("stuff error outside window");

    // R7: a CRC error only at the delimiter.
    p_crc_at_dlm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_crc |-> $past(fld_crc_dlm))
        else $error("CRC error outside delimiter");

    // R9: a bit error always wins the code.
    p_code_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_bit |-> (err_code == ERR_BIT))
        else $error("code priority");

endmodule

// File: tb/test_can_err_detect.sv
`timescale 1ns/1ps
module test_can_err_detect;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0, tx_bit = 1'b1, rx_bit = 1'b1, is_tx = 1'b0, stuff_bit = 1'b0;
    logic [9:0] fsel = '0;
    logic err_bit, err_stuff, err_form, err_ack, err_crc, err_any;
    logic [2:0] err_code;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    can_err_detect i_can_err_detect (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .is_tx(is_tx), .stuff_bit(stuff_bit),
        .fld_sof(fsel[1]), .fld_arb(fsel[2]), .fld_data(fsel[3]), .fld_crc(fsel[4]),
        .fld_crc_dlm(fsel[5]), .fld_ack_slot(fsel[6]), .fld_ack_dlm(fsel[7]),
        .fld_eof(fsel[8]), .fld_ifs(fsel[9]),
        .err_bit(err_bit), .err_stuff(err_stuff), .err_form(err_form), .err_ack(err_ack),
        .err_crc(err_crc), .err_any(err_any), .err_code(err_code)
    );

    // Field index: 0 none,1 sof,2 arb,3 data,4 crc,5 crc_dlm,6 ack_slot,7 ack_dlm,8 eof,9 ifs
    typedef struct packed {
        logic [3:0] fld;
        logic       tx;
        logic       rx;
        logic       istx;
        logic [4:0] exp;   // {crc, ack, form, stuff, bit}
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        {4'd9, 1'b1, 1'b1, 1'b1, 5'b00000},  // R5 idle recessive ok
        {4'd9, 1'b1, 1'b0, 1'b0, 5'b00100},  // R5 dominant in IFS
        {4'd1, 1'b0, 1'b0, 1'b1, 5'b00000},  // R1 SOF match
        {4'd2, 1'b1, 1'b0, 1'b1, 5'b00000},  // R2 lost arbitration
        {4'd2, 1'b0, 1'b1, 1'b1, 5'b00001},  // R1 dominant sent, recessive read
        {4'd3, 1'b1, 1'b0, 1'b1, 5'b00001},  // R2 no exemption in data
        {4'd3, 1'b1, 1'b0, 1'b0, 5'b00000},  // R1 receiver never flags
        {4'd6, 1'b1, 1'b1, 1'b1, 5'b01000},  // R6 missing ack
        {4'd6, 1'b1, 1'b0, 1'b1, 5'b00000},  // R6 R2 ack received
        {4'd6, 1'b1, 1'b1, 1'b0, 5'b00000},  // R6 receiver ignores
        {4'd7, 1'b1, 1'b0, 1'b0, 5'b00100},  // R5 ack delimiter
        {4'd8, 1'b1, 1'b0, 1'b1, 5'b00101},  // R9 bit beats form
        {4'd8, 1'b1, 1'b1, 1'b1, 5'b00000},  // R5 EOF ok
        {4'd3, 1'b0, 1'b0, 1'b0, 5'b00000}   // R1 receiver data
    };

    // Expected code from the flags, following the R9 priority.
    function automatic logic [2:0] exp_code(input logic [4:0] f);
        if (f[0]) return 3'd1;
        if (f[1]) return 3'd2;
        if (f[2]) return 3'd3;
        if (f[3]) return 3'd4;
        if (f[4]) return 3'd5;
        return 3'd0;
    endfunction

    function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
        logic n;
        n = b ^ c[14];
        c = {c[13:0], 1'b0};
        if (n) c = c ^ 15'h4599;
        return c;
    endfunction

    // Strobe one bit and leave the outputs ready to read after the next falling edge.
    task automatic send_bit(input logic [3:0] f, input logic t, input logic r,
                            input logic it, input logic sb);
        @(negedge clk);
        fsel = '0;
        if (f != 0) fsel[f] = 1'b1;
        tx_bit = t; rx_bit = r; is_tx = it; stuff_bit = sb; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0; fsel = '0; stuff_bit = 1'b0;
    endtask

    task automatic check(input string req, input logic [4:0] ex);
        logic [4:0] act;
        act = {err_crc, err_ack, err_form, err_stuff, err_bit};
        n_checks++;
        if (act !== ex || err_code !== exp_code(ex) || err_any !== (|ex)) begin
            n_fails++;
            $display("FAIL %s: flags=%b code=%0d expected flags=%b code=%0d",
                     req, act, err_code, ex, exp_code(ex));
        end
    endtask

    // Frame storage for stuffed whole-frame tests.
    logic       fb  [0:159];
    logic [3:0] ff  [0:159];
    logic       fs  [0:159];
    int         flen;

    // Build a stuffed frame; corrupt flips one CRC bit.
    task automatic build_frame(input logic corrupt);
        logic       db [0:63];
        logic [3:0] df [0:63];
        logic [14:0] c;
        logic [11:0] arb;
        logic [13:0] dat;
        logic last;
        int n, run;
        arb = 12'hA46;
        dat = 14'b000001_00000000;
        n = 0;
        db[n] = 1'b0; df[n] = 4'd1; n++;
        for (int i = 11; i >= 0; i--) begin db[n] = arb[i]; df[n] = 4'd2; n++; end
        for (int i = 13; i >= 0; i--) begin db[n] = dat[i]; df[n] = 4'd3; n++; end
        c = '0;
        for (int i = 0; i < n; i++) c = crc_step(c, db[i]);
        if (corrupt) c[7] = ~c[7];
        for (int i = 14; i >= 0; i--) begin db[n] = c[i]; df[n] = 4'd4; n++; end
        flen = 0; run = 0; last = 1'b1;
        for (int i = 0; i < n; i++) begin
            fb[flen] = db[i]; ff[flen] = df[i]; fs[flen] = 1'b0; flen++;
            if (db[i] == last && i != 0) run++; else run = 1;
            last = db[i];
            if (run == 5) begin
                fb[flen] = ~last; ff[flen] = df[i]; fs[flen] = 1'b1; flen++;
                last = ~last; run = 1;
            end
        end
        fb[flen] = 1'b1; ff[flen] = 4'd5; fs[flen] = 1'b0; flen++;
    endtask

    task automatic run_frame(input string req, input logic [4:0] ex_last);
        int early;
        early = 0;
        for (int i = 0; i < flen; i++) begin
            send_bit(ff[i], 1'b1, fb[i], 1'b0, fs[i]);
            if (i < flen - 1 && err_any) early++;
        end
        check(req, ex_last);
        n_checks++;
        if (early != 0) begin
            n_fails++;
            $display("FAIL %s: %0d errors inside frame, expected 0", req, early);
        end
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        // R10: outputs zero during reset, even with a strobe.
        repeat (2) @(negedge clk);
        fsel = '0; fsel[9] = 1'b1; rx_bit = 1'b0; smp_stb = 1'b1;
        @(negedge clk);
        check("R10 reset", 5'b00000);
        smp_stb = 1'b0; fsel = '0; rx_bit = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk: R1 R2 R5 R6 R9.
        for (int i = 0; i < NV; i++) begin
            send_bit(TBL[i].fld, TBL[i].tx, TBL[i].rx, TBL[i].istx, 1'b0);
            check($sformatf("table vector %0d", i), TBL[i].exp);
        end

        // R8: pulse lasts one cycle.
        send_bit(4'd9, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 pulse present", 5'b00100);
        @(negedge clk);
        check("R8 pulse gone", 5'b00000);

        // R8: inputs without a strobe are ignored.
        @(negedge clk);
        fsel = '0; fsel[9] = 1'b1; rx_bit = 1'b0; tx_bit = 1'b1; is_tx = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 no strobe", 5'b00000);
        fsel = '0; rx_bit = 1'b1; is_tx = 1'b0;

        // R3: run of exactly five, then a sixth equal bit.
        send_bit(4'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) send_bit(4'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 run of five", 5'b00000);
        send_bit(4'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 sixth equal bit", 5'b00010);

        // R3: SOF restarts the run even after dominant bits.
        send_bit(4'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 SOF restart", 5'b00000);

        // R4: long recessive run in EOF and IFS gives no stuff error.
        for (int i = 0; i < 7; i++) send_bit(4'd8, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 EOF run", 5'b00000);
        for (int i = 0; i < 3; i++) send_bit(4'd9, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 IFS run", 5'b00000);

        // R7: correct frame with stuff bits passes; corrupted CRC fails.
        build_frame(1'b0);
        run_frame("R7 good frame", 5'b00000);
        build_frame(1'b1);
        run_frame("R7 corrupt CRC", 5'b10000);

        // R5 R7 R9: dominant CRC delimiter after a good frame gives form, code 3.
        build_frame(1'b0);
        fb[flen-1] = 1'b0;
        run_frame("R5 dominant CRC delimiter", 5'b00100);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule